// File: doc/BRIEF.md
# SPI EEPROM Host Sequencer

This block is the master side of a link to a serial EEPROM on an SPI bus (mode 0: clock idles low, data sampled by both ends on the rising edge, bytes sent most significant bit first). A client presents one request at a time: either a page write of 1 to 32 bytes starting at a 13-bit address, with the data bytes fetched one by one through a take strobe, or a sequential read of N bytes that are returned one by one with a valid strobe.

For a write, the block first sends the write-enable opcode in a chip-select frame of its own, then opens a second frame carrying the write opcode, a 16-bit address and the data, and closes it right after the last data bit so the part commits the page. It then repeatedly reads the status register in separate frames until the busy bit clears, or gives up after a set number of polls. A write that would run past the end of its 32-byte page is refused before any bus activity. The serial clock is derived from the system clock by a parameter, a minimum chip-select high time separates frames, and the hold line is kept inactive.

Top module: `eeprom_spi_host`

## Requirements
- R1: Out of reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1, and done, error, rd_valid and wr_take are 0.
- R2: Bytes go out MSB first in SPI mode 0: spi_sck is 0 whenever spi_cs_n is 1, and spi_mosi does not change while spi_sck is high.
- R3: Every accepted write begins with a frame holding only opcode 0x06; spi_cs_n then rises, and the write frame comes in a later, separate frame.
- R4: The write frame is 0x02, the upper address byte (top three bits zero), the lower address byte, then the req_len data bytes in the order wr_byte presents them; wr_take pulses once per data byte.
- R5: A request with req_len of 0, or a write whose address offset within its 32-byte page (addr[4:0]) plus req_len exceeds 32, produces no frame; done and error rise together two clock edges after the accepting edge.
- R6: spi_cs_n rises only on a byte boundary: every frame holds a multiple of 8 rising clock edges, the last one belonging to the final byte.
- R7: After the write frame, the block sends frames of 0x05 followed by one dummy byte 0x00 and reads bit 0 of the returned byte as busy; it repeats while busy is 1 and pulses done with error 0 after the first poll returning 0.
- R8: If POLL_LIMIT polls in a row all return busy, the block sends no further poll and pulses done with error 1.
- R9: A read is one frame: 0x03, upper and lower address bytes, then req_len dummy bytes 0x00; each byte received during the dummy bytes is presented on rd_byte with a one-cycle rd_valid, in order.
- R10: spi_sck stays high for exactly CLK_DIV clock cycles per bit and low for at least CLK_DIV; spi_cs_n stays high for at least CS_GAP cycles before every falling edge.
- R11: spi_hold_n is 1 at all times.
- R12: done is a one-cycle pulse, error is only asserted together with done, and req_ready drops on the cycle after a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = page write, 0 = sequential read |
| req_addr | input | 13 | Start byte address |
| req_len | input | 6 | Byte count |
| req_ready | output | 1 | Block idle, request accepted when valid is also high |
| wr_byte | input | 8 | Next write data byte |
| wr_take | output | 1 | Pulse: wr_byte consumed, present the next one |
| rd_byte | output | 8 | Read data byte |
| rd_valid | output | 1 | Pulse: rd_byte valid |
| done | output | 1 | Pulse: request finished |
| error | output | 1 | With done: request refused or poll timeout |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |
| spi_hold_n | output | 1 | Hold control, kept high |

## Verification
A refused request is the only result with a fixed latency from the request: the bench samples done and error on the falling clock edge two edges after acceptance, and req_ready on the first falling edge after it. All bus results are timed by the serial clock rather than by the request, so an EEPROM model in the bench samples the pins on every falling system clock edge, reassembles bytes on spi_sck rising edges, drives spi_miso after spi_sck falling edges, and compares each completed frame against a queue of expected frames at the rise of spi_cs_n. Read bytes and completion status are compared in the order they appear against their own expected queues, whatever cycle they arrive in, and any entry left over at the end counts as a failure.

// File: rtl/eeprom_spi_pkg.sv
// Shared opcodes and state types for the SPI EEPROM host sequencer.
// Assumes an EEPROM with 16-bit addressing and bit 0 of the status byte as busy.
package eeprom_spi_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] DUMMY    = 8'h00;

    typedef enum logic [1:0] {
        FR_ENABLE,
        FR_PROGRAM,
        FR_POLL,
        FR_FETCH
    } frame_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_LOAD,
        ST_SHIFT,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/spi_byte_engine.sv
// Shifts one byte out on MOSI and one byte in from MISO in SPI mode 0.
// Each clock phase lasts CLK_DIV system cycles; capture happens as SCK rises.
// Assumes start is only pulsed while the engine is idle.
module spi_byte_engine #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int CNT_W = $clog2(CLK_DIV) + 1;
    localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(CLK_DIV - 1);

    logic             busy;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] div_cnt;
    logic [2:0]       bit_cnt;

    // Phase timing, bit shifting and capture for one byte transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '0;
            rx_byte   <= '0;
            div_cnt   <= '0;
            bit_cnt   <= '0;
            sck       <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    shreg   <= tx_byte;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck     <= 1'b0;
                    shreg   <= {shreg[6:0], 1'b0};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        busy      <= 1'b0;
                        byte_done <= 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    // The most significant remaining bit is always on the line.
    assign mosi = shreg[7];

endmodule

// File: rtl/eeprom_req_screen.sv
// Decides whether a request may run: rejects zero length and any write
// that would pass the end of its page. Purely combinational.
module eeprom_req_screen #(
    parameter int ADDR_W     = 13,
    parameter int LEN_W      = 6,
    parameter int PAGE_BYTES = 32
) (
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic              refuse
);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int SUM_W = ((PG_W > LEN_W) ? PG_W : LEN_W) + 2;

    logic [SUM_W-1:0] page_end;

    // Offset within the page plus byte count must not exceed the page size.
    always_comb begin
        page_end = SUM_W'(addr[PG_W-1:0]) + SUM_W'(len);
        refuse   = (len == '0) || (is_write && (page_end > SUM_W'(PAGE_BYTES)));
    end

endmodule

// File: rtl/eeprom_frame_seq.sv
// Frame-level controller: orders enable, program, status-poll and fetch
// frames, owns chip select and the minimum high time between frames,
// and reports completion. Assumes the byte engine reports each byte once.
module eeprom_frame_seq
    import eeprom_spi_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int LEN_W      = 6,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_refuse,
    output logic              req_ready,
    input  logic [7:0]        wr_byte,
    output logic              wr_take,
    output logic [7:0]        rd_byte,
    output logic              rd_valid,
    output logic              done,
    output logic              error,
    output logic              cs_n,
    output logic              eng_start,
    output logic [7:0]        eng_tx,
    input  logic              eng_done,
    input  logic [7:0]        eng_rx
);
    localparam int IDX_W  = LEN_W + 1;
    localparam int GAP_W  = $clog2(CS_GAP) + 1;
    localparam int POLL_W = $clog2(POLL_LIMIT) + 1;

    seq_state_e        state;
    frame_e            frame;
    logic [IDX_W-1:0]  bidx;
    logic [IDX_W-1:0]  last_idx;
    logic [15:0]       addr16;
    logic [LEN_W-1:0]  len_q;
    logic [GAP_W-1:0]  gap_cnt;
    logic [POLL_W-1:0] poll_cnt;
    logic              fin_err;
    logic              data_phase;

    assign req_ready = (state == ST_IDLE);
    assign eng_start = (state == ST_LOAD);
    assign wr_take   = eng_start && (frame == FR_PROGRAM) && data_phase;

    // Index of the final byte and whether the current byte is a payload byte.
    always_comb begin
        data_phase = (bidx >= IDX_W'(3));
        unique case (frame)
            FR_ENABLE: last_idx = '0;
            FR_POLL:   last_idx = IDX_W'(1);
            default:   last_idx = IDX_W'(len_q) + IDX_W'(2);
        endcase
    end

    // Byte to transmit for the current frame and position.
    always_comb begin
        if (bidx == '0) begin
            unique case (frame)
                FR_ENABLE:  eng_tx = OP_WREN;
                FR_PROGRAM: eng_tx = OP_WRITE;
                FR_POLL:    eng_tx = OP_RDSR;
                default:    eng_tx = OP_READ;
            endcase
        end else if (frame == FR_POLL || frame == FR_ENABLE) begin
            eng_tx = DUMMY;
        end else if (bidx == IDX_W'(1)) begin
            eng_tx = addr16[15:8];
        end else if (bidx == IDX_W'(2)) begin
            eng_tx = addr16[7:0];
        end else if (frame == FR_PROGRAM) begin
            eng_tx = wr_byte;
        end else begin
            eng_tx = DUMMY;
        end
    end

    // Request acceptance, frame ordering, chip select and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            frame    <= FR_ENABLE;
            bidx     <= '0;
            addr16   <= '0;
            len_q    <= '0;
            gap_cnt  <= '0;
            poll_cnt <= '0;
            fin_err  <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
            rd_valid <= 1'b0;
            rd_byte  <= '0;
        end else begin
            done     <= 1'b0;
            error    <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    addr16   <= 16'(req_addr);
                    len_q    <= req_len;
                    gap_cnt  <= '0;
                    poll_cnt <= '0;
                    fin_err  <= req_refuse;
                    frame    <= req_write ? FR_ENABLE : FR_FETCH;
                    state    <= req_refuse ? ST_FIN : ST_GAP;
                end
                ST_GAP: if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
                    cs_n  <= 1'b0;
                    bidx  <= '0;
                    state <= ST_LOAD;
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
                ST_LOAD: state <= ST_SHIFT;
                ST_SHIFT: if (eng_done) begin
                    if (frame == FR_FETCH && data_phase) begin
                        rd_valid <= 1'b1;
                        rd_byte  <= eng_rx;
                    end
                    if (bidx != last_idx) begin
                        bidx  <= bidx + 1'b1;
                        state <= ST_LOAD;
                    end else begin
                        cs_n    <= 1'b1;
                        gap_cnt <= '0;
                        unique case (frame)
                            FR_ENABLE: begin
                                frame <= FR_PROGRAM;
                                state <= ST_GAP;
                            end
                            FR_PROGRAM: begin
                                frame <= FR_POLL;
                                state <= ST_GAP;
                            end
                            FR_POLL: begin
                                if (!eng_rx[0]) begin
                                    fin_err <= 1'b0;
                                    state   <= ST_FIN;
                                end else if (poll_cnt == POLL_W'(POLL_LIMIT - 1)) begin
                                    fin_err <= 1'b1;
                                    state   <= ST_FIN;
                                end else begin
                                    poll_cnt <= poll_cnt + 1'b1;
                                    state    <= ST_GAP;
                                end
                            end
                            default: begin
                                fin_err <= 1'b0;
                                state   <= ST_FIN;
                            end
                        endcase
                    end
                end
                default: begin
                    done  <= 1'b1;
                    error <= fin_err;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/eeprom_spi_host.sv
// Top of the SPI EEPROM host sequencer: request screen, frame sequencer
// and byte engine. Assumes one EEPROM on the bus and SPI mode 0.
module eeprom_spi_host #(
    parameter int CLK_DIV    = 4,
    parameter int CS_GAP     = 4,
    parameter int POLL_LIMIT = 1000,
    parameter int ADDR_W     = 13,
    parameter int LEN_W      = 6,
    parameter int PAGE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    input  logic [7:0]        wr_byte,
    output logic              wr_take,
    output logic [7:0]        rd_byte,
    output logic              rd_valid,
    output logic              done,
    output logic              error,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_hold_n
);
    logic       refuse;
    logic       eng_start;
    logic       eng_done;
    logic [7:0] eng_tx;
    logic [7:0] eng_rx;

    assign spi_hold_n = 1'b1;

    eeprom_req_screen #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) u_screen (
        .is_write(req_write), .addr(req_addr), .len(req_len), .refuse(refuse)
    );

    eeprom_frame_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_refuse(refuse), .req_ready(req_ready),
        .wr_byte(wr_byte), .wr_take(wr_take),
        .rd_byte(rd_byte), .rd_valid(rd_valid),
        .done(done), .error(error), .cs_n(spi_cs_n),
        .eng_start(eng_start), .eng_tx(eng_tx),
        .eng_done(eng_done), .eng_rx(eng_rx)
    );

    spi_byte_engine #(
        .CLK_DIV(CLK_DIV)
    ) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start(eng_start), .tx_byte(eng_tx),
        .byte_done(eng_done), .rx_byte(eng_rx),
        .sck(spi_sck), .mosi(spi_mosi), .miso(spi_miso)
    );

endmodule

// File: rtl/eeprom_spi_host_chk.sv
// Protocol checker for eeprom_spi_host, attached by bind. Watches the
// bus pins and the request handshake only.
module eeprom_spi_host_chk #(
    parameter int CLK_DIV = 4,
    parameter int CS_GAP  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic error,
    input logic spi_sck,
    input logic spi_cs_n,
    input logic spi_mosi,
    input logic spi_hold_n
);
    logic [15:0] cs_high_cnt;
    logic [15:0] sck_high_cnt;
    logic [15:0] sck_low_cnt;

    // Run lengths of chip-select high and clock high/low, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_high_cnt  <= '0;
            sck_high_cnt <= '0;
            sck_low_cnt  <= '0;
        end else begin
            cs_high_cnt  <= !spi_cs_n ? '0 : (&cs_high_cnt  ? cs_high_cnt  : cs_high_cnt + 1'b1);
            sck_high_cnt <= !spi_sck  ? '0 : (&sck_high_cnt ? sck_high_cnt : sck_high_cnt + 1'b1);
            sck_low_cnt  <= spi_sck   ? '0 : (&sck_low_cnt  ? sck_low_cnt  : sck_low_cnt + 1'b1);
        end
    end

    assert_hold_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_hold_n);

    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    assert_mosi_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

    assert_sck_high_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> (sck_high_cnt == 16'(CLK_DIV)));

    assert_sck_low_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> (sck_low_cnt >= 16'(CLK_DIV)));

    assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (cs_high_cnt >= 16'(CS_GAP)));

    assert_error_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_ready_drop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind eeprom_spi_host eeprom_spi_host_chk #(
    .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .done(done), .error(error), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_hold_n(spi_hold_n)
);

// File: tb/eeprom_spi_host_bench.sv
// Scoreboard bench: driver tasks queue expected frames, read bytes and
// completions; an EEPROM model and monitors compare as results appear.
module eeprom_spi_host_bench;
    localparam int CLK_DIV    = 2;
    localparam int CS_GAP     = 3;
    localparam int POLL_LIMIT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [5:0]  req_len = '0;
    logic        req_ready;
    logic [7:0]  wr_byte;
    logic        wr_take;
    logic [7:0]  rd_byte;
    logic        rd_valid;
    logic        done;
    logic        error;
    logic        spi_sck;
    logic        spi_cs_n;
    logic        spi_mosi;
    logic        spi_miso = 1'b0;
    logic        spi_hold_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    eeprom_spi_host #(
        .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)
    ) u_eeprom_spi_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_ready(req_ready),
        .wr_byte(wr_byte), .wr_take(wr_take), .rd_byte(rd_byte),
        .rd_valid(rd_valid), .done(done), .error(error), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_hold_n(spi_hold_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected results
    int         exp_flen[$];
    logic [7:0] exp_fbyte[$];
    logic [7:0] exp_rd[$];
    bit         exp_err[$];

    logic [7:0] ref_mem [256];
    logic [7:0] wq [32];
    int         take_cnt = 0;
    int         take_base = 0;
    int         busy_init = 0;

    assign wr_byte = wq[5'(take_cnt - take_base)];

    always @(posedge clk) if (wr_take) take_cnt <= take_cnt + 1;

    // EEPROM model, sampled away from the active edge
    logic [7:0] mem [256];
    logic [7:0] fb[$];
    logic [7:0] in_sh = '0;
    logic [7:0] out_sh = '0;
    int         fbits = 0;
    int         bc = 0;
    int         busy_cnt = 0;
    bit         wel = 1'b0;
    bit         in_frame = 1'b0;
    logic       prev_cs = 1'b1;
    logic       prev_sck = 1'b0;
    int         hi_w = 0;
    int         cs_hi = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sck) hi_w++;
            if (prev_cs && !spi_cs_n) begin
                chk(cs_hi >= CS_GAP, "R10 cs high gap", cs_hi, CS_GAP);
                fb.delete();
                fbits = 0; bc = 0; out_sh = '0; in_frame = 1'b1;
            end
            if (!spi_cs_n && !prev_sck && spi_sck) begin
                in_sh = {in_sh[6:0], spi_mosi};
                fbits++; bc++;
                if (bc == 8) begin
                    bc = 0;
                    fb.push_back(in_sh);
                    out_sh = '0;
                    if (fb[0] == 8'h05) out_sh = {7'b0, busy_cnt > 0};
                    else if (fb[0] == 8'h03 && fb.size() >= 3)
                        out_sh = mem[8'(int'({fb[1], fb[2]}) + fb.size() - 3)];
                end
            end
            if (!spi_cs_n && prev_sck && !spi_sck) begin
                chk(hi_w == CLK_DIV, "R10 sck high width", hi_w, CLK_DIV);
                spi_miso = out_sh[7];
                out_sh = {out_sh[6:0], 1'b0};
            end
            if (!spi_sck) hi_w = 0;
            if (!prev_cs && spi_cs_n && in_frame) begin
                in_frame = 1'b0;
                chk(fbits == 8 * fb.size(), "R6 bits per frame", fbits, 8 * fb.size());
                if (exp_flen.size() == 0) begin
                    chk(1'b0, "R3 R5 unexpected frame", fb.size(), 0);
                end else begin
                    int n;
                    n = exp_flen.pop_front();
                    chk(n == fb.size(), "R3 R4 R7 R9 frame length", fb.size(), n);
                    for (int i = 0; i < n; i++) begin
                        logic [7:0] e;
                        e = exp_fbyte.pop_front();
                        if (i < fb.size())
                            chk(fb[i] == e, "R3 R4 R7 R9 frame byte", fb[i], e);
                    end
                end
                if (fb.size() >= 2 && fb[0] == 8'h02)
                    chk(fb[1][7:5] == 3'b0, "R4 address top bits", fb[1][7:5], 0);
                if (fb.size() == 1 && fb[0] == 8'h06 && fbits == 8) wel = 1'b1;
                if (fb.size() >= 4 && fb[0] == 8'h02 && fbits == 8 * fb.size() && wel) begin
                    for (int i = 3; i < fb.size(); i++)
                        mem[{fb[2][7:5], 5'(fb[2][4:0] + 5'(i - 3))}] = fb[i];
                    wel = 1'b0;
                    busy_cnt = busy_init;
                end
                if (fb.size() >= 1 && fb[0] == 8'h05 && busy_cnt > 0) busy_cnt--;
            end
            cs_hi = spi_cs_n ? cs_hi + 1 : 0;
            prev_cs  = spi_cs_n;
            prev_sck = spi_sck;
        end
    end

    // Monitor: read bytes and completions in order
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) chk(1'b0, "R9 unexpected read byte", rd_byte, 0);
            else begin
                logic [7:0] e;
                e = exp_rd.pop_front();
                chk(rd_byte == e, "R9 read data", rd_byte, e);
            end
        end
        if (rst_n && done) begin
            if (exp_err.size() == 0) chk(1'b0, "R12 unexpected done", 1, 0);
            else begin
                bit e;
                e = exp_err.pop_front();
                chk(error == e, "R7 R8 R5 completion error", error, e);
            end
        end
    end

    task automatic push_frame3(input logic [7:0] op, input int a);
        exp_fbyte.push_back(op);
        exp_fbyte.push_back({3'b0, 5'(a >> 8)});
        exp_fbyte.push_back(8'(a));
    endtask

    task automatic issue(input bit w, input int a, input int n, input bit bad);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = 13'(a); req_len = 6'(n);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R12 ready drops after accept", req_ready, 0);
        if (bad) begin
            chk(!done, "R5 no done one edge after accept", done, 0);
            @(negedge clk);
            chk(done && error, "R5 refusal timing", {done, error}, 3);
        end else begin
            while (!done) @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic do_write(input int a, input int n, input int busy);
        bit bad;
        int polls;
        bad = (n == 0) || (n > 32) || ((a % 32) + n > 32);
        for (int i = 0; i < 32; i++) wq[i] = 8'(a * 3 + i * 29 + 17);
        take_base = take_cnt;
        busy_init = busy;
        if (!bad) begin
            exp_flen.push_back(1);
            exp_fbyte.push_back(8'h06);
            exp_flen.push_back(3 + n);
            push_frame3(8'h02, a);
            for (int i = 0; i < n; i++) begin
                exp_fbyte.push_back(wq[i]);
                ref_mem[8'(a + i)] = wq[i];
            end
            polls = (busy < POLL_LIMIT) ? busy + 1 : POLL_LIMIT;
            for (int p = 0; p < polls; p++) begin
                exp_flen.push_back(2);
                exp_fbyte.push_back(8'h05);
                exp_fbyte.push_back(8'h00);
            end
        end
        exp_err.push_back(bad || (busy >= POLL_LIMIT));
        issue(1'b1, a, n, bad);
        chk(take_cnt - take_base == (bad ? 0 : n), "R4 R5 wr_take count",
            take_cnt - take_base, bad ? 0 : n);
    endtask

    task automatic do_read(input int a, input int n);
        bit bad;
        bad = (n == 0);
        if (!bad) begin
            exp_flen.push_back(3 + n);
            push_frame3(8'h03, a);
            for (int i = 0; i < n; i++) begin
                exp_fbyte.push_back(8'h00);
                exp_rd.push_back(ref_mem[8'(a + i)]);
            end
        end
        exp_err.push_back(bad);
        issue(1'b0, a, n, bad);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        for (int i = 0; i < 32; i++) wq[i] = '0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(spi_cs_n && !spi_sck && req_ready && !done && !error && !rd_valid && !wr_take,
            "R1 reset outputs", {spi_cs_n, spi_sck, req_ready, done, error}, 5'b10100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_hold_n, "R11 hold high", spi_hold_n, 1);

        do_read(13'h0040, 4);            // R9 plain read
        do_write(13'h0044, 4, 2);        // R3 R4 R7 two busy polls
        do_read(13'h0042, 8);            // R9 read back across written bytes
        do_write(13'h1FE0, 32, 0);       // R4 full page, ready at first poll
        do_read(13'h1FE0, 32);           // R9 long read
        do_write(13'h0065, 27, 1);       // R4 ends exactly at page end
        do_write(13'h003C, 8, 0);        // R5 crosses page
        do_write(13'h0010, 0, 0);        // R5 zero length
        do_write(13'h0000, 33, 0);       // R5 over a page
        do_read(13'h0005, 0);            // R5 zero-length read
        do_write(13'h0010, 2, 9);        // R8 poll timeout
        do_read(13'h00FE, 3);            // R9 read wraps model index
        do_write(13'h0080, 1, 3);        // R7 single byte, three busy polls
        do_read(13'h0060, 32);           // R9 checks previous writes

        chk(spi_hold_n, "R11 hold high at end", spi_hold_n, 1);
        chk(exp_flen.size() == 0, "R7 R9 frames left over", exp_flen.size(), 0);
        chk(exp_rd.size() == 0, "R9 read bytes left over", exp_rd.size(), 0);
        chk(exp_err.size() == 0, "R12 completions left over", exp_err.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R12 watchdog expired actual=busy expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule